// File: doc/BRIEF.md
# Flag-Setting ALU with Status Register

This block is a 32-bit arithmetic and logic unit that keeps its own four-bit condition status (negative, zero, carry, overflow) in a register. Before each operation, the second operand is passed through an immediate shifter that moves it left or right by a given amount. The shifter also produces a carry, which is the last bit it pushed out. That carry is used as the status carry by the logical operations.

Opcodes are four bits wide and fall into two groups. Opcodes with bit 3 set only evaluate a condition. Compare and compare-negated run the adder. Test and test-equivalence run the logic path. None of these four ever writes back a result, but each of them always updates the status. Opcodes with bit 3 clear are add, add-with-carry, subtract and AND. Each of these writes back its result and changes the status only when the set-flags input is high. Add-with-carry folds the registered carry into bit 0, so wide sums can be built one word at a time.

Operations are accepted on every cycle in which `op_en` is high, and there is no back-pressure. The result, its one-cycle write-back strobe and the new status all appear after the next rising edge. An operation issued on the very next cycle therefore already sees the updated status.

Top module: `flag_alu`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `flags` is 0000, `result` is 0 and `result_valid` is 0.
- R2: The opcodes ADD=0x0, ADC=0x1, SUB=0x2 and AND=0x3, issued with `op_en` high, load `result` on the next rising edge and pulse `result_valid` high for exactly that one cycle.
- R3: ADD, ADC, SUB and AND change `flags` only when `set_flags` is 1. With `set_flags` at 0, `flags` stays unchanged.
- R4: The opcodes CMP=0x8 (A minus B), CMN=0x9 (A plus B), TST=0xA (A AND B) and TEQ=0xB (A XOR B) never raise `result_valid` and leave `result` unchanged. They always update `flags`, whatever `set_flags` is.
- R5: The flags are packed as `flags[3]`=N, `flags[2]`=Z, `flags[1]`=C and `flags[0]`=V. N is bit 31 of the computed value. Z is 1 exactly when all 32 bits of that value are zero.
- R6: For SUB and CMP, the adder forms A + ~B + 1, and C is its carry out, so C=1 means A is unsigned higher than or the same as B. For ADD, ADC and CMN, C is the carry out of bit 31. For all adder opcodes, V is the carry into bit 31 XOR the carry out of bit 31.
- R7: The shifter moves B left (`shift_right`=0) or right (`shift_right`=1), filling with zeros, by `shift_amt` places (0 to 31).
- R8: For AND, TST and TEQ, C becomes the last bit the shifter pushed out, and V keeps its old value. When `shift_amt` is 0, C keeps its old value.
- R9: ADC adds the registered C into bit 0. A flag update is visible to the operation issued on the following cycle, so an ADD with flags followed by an ADC yields a correct 64-bit sum.
- R10: With `op_en` low, or with any opcode outside the eight listed above, `result`, `result_valid` and `flags` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_en | input | 1 | Issue the operation on this cycle |
| opcode | input | 4 | Operation code |
| set_flags | input | 1 | Allow result-producing opcodes to update the flags |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, before shifting |
| shift_right | input | 1 | Shift direction: 0 left, 1 right |
| shift_amt | input | 5 | Shift distance |
| result | output | 32 | Last written-back result |
| result_valid | output | 1 | One-cycle write-back strobe |
| flags | output | 4 | Registered N, Z, C, V |

## Verification
In one cycle, a flag write and a read of that same flag can coincide. An ADC issued directly after a flag-setting ADD must consume the carry that is being written on that very edge. The bench provokes this by issuing the low-word ADD and the high-word ADC back to back, with `op_en` held high, and then comparing the high word against a 64-bit sum it computed itself. The same pattern is checked for the logic path: a test with a zero shift amount follows a compare, and its carry and overflow must equal the values the compare left behind.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'h0,
    OP_ADC = 4'h1,
    OP_SUB = 4'h2,
    OP_AND = 4'h3,
    OP_CMP = 4'h8,
    OP_CMN = 4'h9,
    OP_TST = 4'hA,
    OP_TEQ = 4'hB
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/flag_alu_shifter.sv
module flag_alu_shifter #(
  parameter int DW  = 32,
  parameter int SHW = $clog2(DW)
) (
  input  logic [DW-1:0]  operand,
  input  logic           right,
  input  logic [SHW-1:0] amt,
  input  logic           c_keep,
  output logic [DW-1:0]  shifted,
  output logic           c_out
);
  logic [DW:0] ext_r;
  logic [DW:0] ext_l;

  // extra bit beside the operand catches the last bit pushed out
  assign ext_r = {operand, 1'b0} >> amt;
  assign ext_l = {1'b0, operand} << amt;

  always_comb begin
    if (amt == '0) begin
      shifted = operand;
      c_out   = c_keep;
    end else if (right) begin
      shifted = ext_r[DW:1];
      c_out   = ext_r[0];
    end else begin
      shifted = ext_l[DW-1:0];
      c_out   = ext_l[DW];
    end
  end
endmodule

// File: rtl/flag_alu_core.sv
module flag_alu_core
  import flag_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [3:0]    opcode,
  input  logic          en,
  input  logic          set_flags,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] bs,
  input  logic          sh_c,
  input  flags_t        cur,
  output logic [DW-1:0] value,
  output logic          wr_en,
  output logic          flag_we,
  output flags_t        nxt
);
  logic          known;
  logic          arith;
  logic [DW-1:0] b_op;
  logic          cin;
  logic [DW:0]   sum;
  logic          c_msb_in;
  logic          c_msb_out;

  always_comb begin
    known = 1'b1;
    arith = 1'b1;
    b_op  = bs;
    cin   = 1'b0;
    case (opcode)
      OP_ADD, OP_CMN: ;
      OP_ADC:         cin = cur.c;
      OP_SUB, OP_CMP: begin b_op = ~bs; cin = 1'b1; end
      OP_AND, OP_TST, OP_TEQ: arith = 1'b0;
      default: begin known = 1'b0; arith = 1'b0; end
    endcase
  end

  assign sum       = {1'b0, a} + {1'b0, b_op} + {{DW{1'b0}}, cin};
  assign c_msb_out = sum[DW];
  assign c_msb_in  = sum[DW-1] ^ a[DW-1] ^ b_op[DW-1];

  always_comb begin
    if (arith)                value = sum[DW-1:0];
    else if (opcode == OP_TEQ) value = a ^ bs;
    else                      value = a & bs;
  end

  assign wr_en   = en && known && !opcode[3];
  assign flag_we = en && known && (opcode[3] || set_flags);

  always_comb begin
    nxt.n = value[DW-1];
    nxt.z = (value == '0);
    nxt.c = arith ? c_msb_out : sh_c;
    nxt.v = arith ? (c_msb_in ^ c_msb_out) : cur.v;
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DW  = 32,
  parameter int SHW = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_en,
  input  logic [3:0]     opcode,
  input  logic           set_flags,
  input  logic [DW-1:0]  opnd_a,
  input  logic [DW-1:0]  opnd_b,
  input  logic           shift_right,
  input  logic [SHW-1:0] shift_amt,
  output logic [DW-1:0]  result,
  output logic           result_valid,
  output logic [3:0]     flags
);
  flags_t        flags_q;
  flags_t        flags_d;
  logic [DW-1:0] b_sh;
  logic          sh_c;
  logic [DW-1:0] value;
  logic          wr_en;
  logic          flag_we;
  logic [DW-1:0] res_q;
  logic          vld_q;

  flag_alu_shifter #(.DW(DW), .SHW(SHW)) shf_i (
    .operand (opnd_b),
    .right   (shift_right),
    .amt     (shift_amt),
    .c_keep  (flags_q.c),
    .shifted (b_sh),
    .c_out   (sh_c)
  );

  flag_alu_core #(.DW(DW)) core_i (
    .opcode    (opcode),
    .en        (op_en),
    .set_flags (set_flags),
    .a         (opnd_a),
    .bs        (b_sh),
    .sh_c      (sh_c),
    .cur       (flags_q),
    .value     (value),
    .wr_en     (wr_en),
    .flag_we   (flag_we),
    .nxt       (flags_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      res_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= wr_en;
      if (wr_en)   res_q   <= value;
      if (flag_we) flags_q <= flags_d;
    end
  end

  assign result       = res_q;
  assign result_valid = vld_q;
  assign flags        = flags_q;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_en,
  input logic [3:0]    opcode,
  input logic          set_flags,
  input logic [DW-1:0] result,
  input logic          result_valid,
  input logic [3:0]    flags
);
  // R2
  strobe_from_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(op_en));

  // R2
  strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && opcode[3:2] == 2'b00) |=> result_valid);

  // R4
  flag_only_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && opcode[3]) |=> (!result_valid && $stable(result)));

  // R3
  no_s_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && !opcode[3] && !set_flags) |=> $stable(flags));

  // R10
  idle_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> ($stable(flags) && $stable(result) && !result_valid));

  // R5
  nz_match_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && $past(set_flags)) |->
      (flags[3] == result[DW-1] && flags[2] == (result == '0)));
endmodule

bind flag_alu flag_alu_chk #(.DW(DW)) chk_i (.*);

// File: tb/flag_alu_tb_top.sv
module flag_alu_tb_top;
  typedef struct packed {
    logic [3:0]  op;
    logic        s;
    logic [31:0] a;
    logic [31:0] b;
    logic        shr;
    logic [4:0]  amt;
    logic        wr;
    logic [31:0] res;
    logic [3:0]  flg;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  // flags NZCV; each row runs right after the previous one
  localparam vec_t VECS [NV] = '{
    '{4'h8,1'b0,32'h7FFFFFFF,32'hFFFFFFFF,1'b0,5'd0,1'b0,32'h0,4'b1001,8'd6},  // R6 CMP
    '{4'h8,1'b1,32'h7FFFFFFF,32'hFFFFFFFF,1'b0,5'd2,1'b0,32'h0,4'b1001,8'd4},  // R4 CMP lsl2
    '{4'h9,1'b0,32'h7FFFFFFF,32'hFFFFFFFF,1'b0,5'd2,1'b0,32'h0,4'b0010,8'd6},  // R6 CMN
    '{4'hA,1'b0,32'h7FFFFFFF,32'hFFFFFFFF,1'b1,5'd1,1'b0,32'h0,4'b0010,8'd8},  // R8 TST
    '{4'hB,1'b0,32'h7FFFFFFF,32'hFFFFFFFF,1'b1,5'd1,1'b0,32'h0,4'b0110,8'd5},  // R5 TEQ
    '{4'h8,1'b0,32'h7FFFFFFF,32'hFFFFFFFF,1'b0,5'd0,1'b0,32'h0,4'b1001,8'd6},  // R6 set V
    '{4'hA,1'b0,32'h80000000,32'h80000000,1'b0,5'd0,1'b0,32'h0,4'b1001,8'd8},  // R8 amt0
    '{4'h0,1'b0,32'h5,32'h3,1'b0,5'd0,1'b1,32'h8,4'b1001,8'd3},                // R3 no S
    '{4'h0,1'b1,32'hFFFFFFFF,32'h1,1'b0,5'd0,1'b1,32'h0,4'b0110,8'd2},         // R2 ADD S
    '{4'h1,1'b0,32'h10,32'h20,1'b0,5'd0,1'b1,32'h31,4'b0110,8'd9},             // R9 ADC C=1
    '{4'h2,1'b1,32'h3,32'h5,1'b0,5'd0,1'b1,32'hFFFFFFFE,4'b1000,8'd6},         // R6 borrow
    '{4'h2,1'b1,32'h80000000,32'h1,1'b0,5'd0,1'b1,32'h7FFFFFFF,4'b0011,8'd6},  // R6 V
    '{4'h3,1'b1,32'hF0F0F0F0,32'h0000000F,1'b0,5'd4,1'b1,32'hF0,4'b0001,8'd7}, // R7 AND lsl
    '{4'h0,1'b1,32'h0,32'h100,1'b1,5'd8,1'b1,32'h1,4'b0000,8'd7},              // R7 ADD lsr
    '{4'h4,1'b1,32'h0,32'h0,1'b0,5'd0,1'b0,32'h0,4'b0000,8'd10},               // R10 bad op
    '{4'h1,1'b1,32'h1,32'h1,1'b0,5'd0,1'b1,32'h2,4'b0000,8'd9},                // R9 ADC C=0
    '{4'h0,1'b1,32'hFFFFFFFF,32'h00000001,1'b0,5'd0,1'b1,32'h0,4'b0110,8'd9},  // R9 low word
    '{4'h1,1'b1,32'h00000001,32'h00000002,1'b0,5'd0,1'b1,32'h4,4'b0000,8'd9}   // R9 high word
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_en = 1'b0;
  logic [3:0]  opcode = '0;
  logic        set_flags = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        shift_right = 1'b0;
  logic [4:0]  shift_amt = '0;
  logic [31:0] result;
  logic        result_valid;
  logic [3:0]  flags;

  int errors = 0;
  int checks = 0;
  logic [31:0] last_res = '0;

  always #4 clk = ~clk;

  flag_alu dut_i (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .opcode(opcode),
    .set_flags(set_flags), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .shift_right(shift_right), .shift_amt(shift_amt),
    .result(result), .result_valid(result_valid), .flags(flags)
  );

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input int req, input logic [31:0] er,
                           input logic ev, input logic [3:0] ef);
    check(result == er, req, "result", result, er);
    check(result_valid == ev, req, "valid", {31'b0, result_valid}, {31'b0, ev});
    check(flags == ef, req, "flags", {28'b0, flags}, {28'b0, ef});
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 state during reset
    check_all(1, 32'h0, 1'b0, 4'b0000);
    rst_n = 1'b1;
    @(posedge clk); #2;
    // R1 state just after release
    check_all(1, 32'h0, 1'b0, 4'b0000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      op_en = 1'b1;
      opcode = VECS[i].op; set_flags = VECS[i].s;
      opnd_a = VECS[i].a; opnd_b = VECS[i].b;
      shift_right = VECS[i].shr; shift_amt = VECS[i].amt;
      @(posedge clk); #2;
      op_en = 1'b0;
      if (VECS[i].wr) last_res = VECS[i].res;
      check_all(int'(VECS[i].req), last_res, VECS[i].wr, VECS[i].flg);
    end

    // R10: op_en low with a flag-only opcode does nothing
    @(negedge clk);
    opcode = 4'h8; opnd_a = 32'h0; opnd_b = 32'h0; set_flags = 1'b1;
    @(posedge clk); #2;
    check_all(10, last_res, 1'b0, 4'b0000);

    // R2: strobe lasts one cycle only
    @(negedge clk);
    op_en = 1'b1; opcode = 4'h3; set_flags = 1'b0;
    opnd_a = 32'hFFFF0000; opnd_b = 32'h0FF00FF0; shift_amt = 5'd0;
    @(posedge clk); #2;
    op_en = 1'b0;
    check_all(2, 32'h0FF00000, 1'b1, 4'b0000);
    @(posedge clk); #2;
    check_all(2, 32'h0FF00000, 1'b0, 4'b0000);

    // R4: test with S=0 still updates flags, result kept
    @(negedge clk);
    op_en = 1'b1; opcode = 4'hA; set_flags = 1'b0;
    opnd_a = 32'h80000001; opnd_b = 32'h00000003; shift_right = 1'b0; shift_amt = 5'd31;
    @(posedge clk); #2;
    op_en = 1'b0;
    // b lsl 31 = 0x80000000, last out = bit1 of b = 1
    check_all(4, 32'h0FF00000, 1'b0, 4'b1010);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); #2;
    check_all(1, 32'h0, 1'b0, 4'b0000);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule